// File: doc/BRIEF.md
# Endian-Aware Byte Lane Steering

This block sits between a 32-bit register-side data path and a byte-addressed 32-bit memory bus whose four byte lanes are selected by active-low enables. Each request gives a byte address, a transfer size and a static endianness mode. The block produces the word address and the lane enables, places the register's bytes on the right lanes for a write, and collects the addressed lanes back into a right-justified, zero-extended register value for a read.

In little-endian mode the least significant register byte goes to the lowest byte address of the field. In big-endian mode the most significant register byte goes there. A field is addressed by its lowest byte address. Halfword and word requests that break the 2N and 4N alignment rules are not split into several transfers. They are flagged as errors, and no lane is enabled. All results are registered and update once per request strobe.

Top module: `lane_steer`

## Requirements
- R1: One clock after a strobe, `busAddr` equals bits 31..2 of the request address.
- R2: Lane k is carried on data bits 8k+7..8k and is enabled by `byteEnN[k]` (0 = active). Let off be address bits 1..0. The size code is 0 for byte, 1 for halfword and 2 for word, giving n = 1, 2 or 4 bytes. On an aligned request, exactly lanes off to off+n-1 are enabled.
- R3: Outputs change only at a rising edge where `reqValid` is sampled high. `respValid` is high during the cycle that follows such an edge and low otherwise. With no strobe, all outputs hold their values.
- R4: In little-endian mode (`bigEndian`=0), register byte i of a write goes on lane off+i.
- R5: In big-endian mode (`bigEndian`=1), register byte i of a write goes on lane off+n-1-i. On every write, lanes outside the field carry zero.
- R6: On a read, register byte i of `rdData` takes lane off+i in little-endian mode and lane off+n-1-i in big-endian mode. Bytes n and above are zero.
- R7: A request is misaligned in any of these cases: a halfword with address bit 0 set, a word with address bit 1 or bit 0 set, or the reserved size code 3. For a misaligned request, `misalign` is 1, `byteEnN` is 4'hF, and both `busWrData` and `rdData` are zero. For an aligned request, `misalign` is 0.
- R8: Synchronous reset sets `byteEnN` to 4'hF and clears `misalign`, `respValid`, `busAddr`, `busWrData` and `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| bigEndian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| addr | input | 32 | Byte address of the field |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| wrData | input | 32 | Right-justified register value to write |
| busRdData | input | 32 | Bus lanes presented with the strobe for a read |
| busAddr | output | 30 | Registered word address |
| byteEnN | output | 4 | Registered active-low lane enables |
| busWrData | output | 32 | Registered lane-steered write data |
| rdData | output | 32 | Registered gathered, zero-extended read value |
| misalign | output | 1 | Registered alignment error |
| respValid | output | 1 | High during the cycle after a strobe |

## Verification
Every result passes through one register, so each one is due at the first rising edge after the strobe is sampled. The bench raises the strobe at a falling edge and lowers it at the next falling edge. It then samples all outputs, including `respValid`, at that falling edge, half a cycle after they change. To show that outputs hold without a strobe, the bench changes every input while the strobe stays low. It then samples again one and two cycles later and expects the values to be unchanged.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             clear;
    logic             bigEnd;
    logic [OFS_W-1:0] offset;
    logic [OFS_W-1:0] lastIdx;
  } steer_ctl_t;
endpackage

// File: rtl/lane_steer_ctrl.sv
module lane_steer_ctrl
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic                    bigEndian,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [1:0]              size,
  output steer_ctl_t              ctl,
  output logic [ADDR_W-OFS_W-1:0] busAddr,
  output logic [LANES-1:0]        byteEnN,
  output logic                    misalign,
  output logic                    respValid
);
  logic [OFS_W-1:0] offset;
  logic [OFS_W-1:0] lastIdx;
  logic             errNow;
  logic [LANES-1:0] laneMask;

  assign offset = addr[OFS_W-1:0];

  always_comb begin
    lastIdx = '0;
    errNow  = 1'b0;
    unique case (xfer_size_e'(size))
      SZ_BYTE: begin lastIdx = OFS_W'(0); errNow = 1'b0;        end
      SZ_HALF: begin lastIdx = OFS_W'(1); errNow = addr[0];     end
      SZ_WORD: begin lastIdx = OFS_W'(3); errNow = |addr[1:0];  end
      default: begin lastIdx = OFS_W'(0); errNow = 1'b1;        end
    endcase
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [OFS_W:0] lo, hi;
      assign lo = {1'b0, offset};
      assign hi = {1'b0, offset} + {1'b0, lastIdx};
      assign laneMask[k] = !errNow && ((OFS_W+1)'(k) >= lo) && ((OFS_W+1)'(k) <= hi);
    end
  endgenerate

  always_comb begin
    ctl.load    = reqValid;
    ctl.clear   = errNow;
    ctl.bigEnd  = bigEndian;
    ctl.offset  = offset;
    ctl.lastIdx = lastIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddr   <= '0;
      byteEnN   <= '1;
      misalign  <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= reqValid;
      if (reqValid) begin
        busAddr  <= addr[ADDR_W-1:OFS_W];
        byteEnN  <= ~laneMask;
        misalign <= errNow;
      end
    end
  end
endmodule

// File: rtl/lane_steer_dp.sv
module lane_steer_dp
  import lane_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  steer_ctl_t        ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] wrNext;
  logic [DATA_W-1:0] rdNext;

  // lane that holds register byte idx of the field
  function automatic logic [OFS_W-1:0] laneOf(input steer_ctl_t c, input logic [OFS_W-1:0] idx);
    if (c.bigEnd) laneOf = c.offset + c.lastIdx - idx;
    else          laneOf = c.offset + idx;
  endfunction

  always_comb begin
    wrNext = '0;
    rdNext = '0;
    for (int i = 0; i < LANES; i++) begin
      if (OFS_W'(i) <= ctl.lastIdx) begin
        wrNext[laneOf(ctl, OFS_W'(i))*LANE_W +: LANE_W] = wrData[i*LANE_W +: LANE_W];
        rdNext[i*LANE_W +: LANE_W] = busRdData[laneOf(ctl, OFS_W'(i))*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busWrData <= '0;
      rdData    <= '0;
    end else if (ctl.load) begin
      busWrData <= ctl.clear ? '0 : wrNext;
      rdData    <= ctl.clear ? '0 : rdNext;
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import lane_steer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  input  logic                    bigEndian,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [1:0]              size,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [DATA_W-1:0]       busRdData,
  output logic [ADDR_W-OFS_W-1:0] busAddr,
  output logic [LANES-1:0]        byteEnN,
  output logic [DATA_W-1:0]       busWrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    misalign,
  output logic                    respValid
);
  steer_ctl_t ctl;

  lane_steer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .bigEndian(bigEndian),
    .addr(addr), .size(size), .ctl(ctl), .busAddr(busAddr),
    .byteEnN(byteEnN), .misalign(misalign), .respValid(respValid)
  );

  lane_steer_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .wrData(wrData),
    .busRdData(busRdData), .busWrData(busWrData), .rdData(rdData)
  );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic [1:0]  size,
  input logic [3:0]  byteEnN,
  input logic [31:0] rdData,
  input logic [31:0] busWrData,
  input logic        misalign,
  input logic        respValid
);
  a_r3_resp_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> respValid);

  a_r3_no_resp_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !respValid);

  a_r3_enables_hold: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(byteEnN));

  a_r2_enable_count: assert property (@(posedge clk) disable iff (rst)
    (respValid && !misalign) |->
      ($countones(~byteEnN) == (($past(size) == 2'd0) ? 1 : ($past(size) == 2'd1) ? 2 : 4)));

  a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (respValid && $past(size) == 2'd0) |-> (rdData[31:8] == 24'h0));

  a_r7_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (byteEnN == 4'hF && rdData == 32'h0 && busWrData == 32'h0));
endmodule

bind lane_steer lane_steer_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .size(size),
  .byteEnN(byteEnN), .rdData(rdData), .busWrData(busWrData),
  .misalign(misalign), .respValid(respValid)
);

// File: tb/tb_lane_steer.sv
module tb_lane_steer;
  localparam time CLK_PERIOD = 20ns;
  localparam logic [31:0] WR_VAL = 32'h11223344;
  localparam logic [31:0] RD_VAL = 32'hAABBCCDD;

  typedef struct packed {
    logic        big;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [3:0]  expEn;
    logic [31:0] expWr;
    logic [31:0] expRd;
    logic        expMis;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hCAFE0000, 2'd0, 4'b1110, 32'h00000044, 32'h000000DD, 1'b0},
    '{1'b0, 32'hCAFE0013, 2'd0, 4'b0111, 32'h44000000, 32'h000000AA, 1'b0},
    '{1'b1, 32'h12340001, 2'd0, 4'b1101, 32'h00004400, 32'h000000CC, 1'b0},
    '{1'b0, 32'h0000F002, 2'd1, 4'b0011, 32'h33440000, 32'h0000AABB, 1'b0},
    '{1'b1, 32'h0000F006, 2'd1, 4'b0011, 32'h44330000, 32'h0000BBAA, 1'b0},
    '{1'b0, 32'h80000000, 2'd1, 4'b1100, 32'h00003344, 32'h0000CCDD, 1'b0},
    '{1'b1, 32'h80000004, 2'd1, 4'b1100, 32'h00004433, 32'h0000DDCC, 1'b0},
    '{1'b0, 32'hFFFFFFFC, 2'd2, 4'b0000, 32'h11223344, 32'hAABBCCDD, 1'b0},
    '{1'b1, 32'h00000100, 2'd2, 4'b0000, 32'h44332211, 32'hDDCCBBAA, 1'b0},
    '{1'b0, 32'h00000201, 2'd1, 4'b1111, 32'h00000000, 32'h00000000, 1'b1},
    '{1'b1, 32'h00000302, 2'd2, 4'b1111, 32'h00000000, 32'h00000000, 1'b1},
    '{1'b0, 32'h00000401, 2'd2, 4'b1111, 32'h00000000, 32'h00000000, 1'b1},
    '{1'b0, 32'h00000500, 2'd3, 4'b1111, 32'h00000000, 32'h00000000, 1'b1},
    '{1'b1, 32'h00000602, 2'd0, 4'b1011, 32'h00440000, 32'h000000BB, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        bigEndian = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wrData = '0;
  logic [31:0] busRdData = '0;
  logic [29:0] busAddr;
  logic [3:0]  byteEnN;
  logic [31:0] busWrData;
  logic [31:0] rdData;
  logic        misalign;
  logic        respValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_steer dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .bigEndian(bigEndian),
    .addr(addr), .size(size), .wrData(wrData), .busRdData(busRdData),
    .busAddr(busAddr), .byteEnN(byteEnN), .busWrData(busWrData),
    .rdData(rdData), .misalign(misalign), .respValid(respValid)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic big, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    bigEndian = big; addr = a; size = s;
    wrData = WR_VAL; busRdData = RD_VAL; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  holdEn;
    logic [31:0] holdWr;
    logic [31:0] holdRd;
    logic [29:0] holdAddr;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 byteEnN", 32'(byteEnN), 32'hF);
    check("R8 misalign", 32'(misalign), 32'h0);
    check("R8 respValid", 32'(respValid), 32'h0);
    check("R8 busWrData", busWrData, 32'h0);
    check("R8 rdData", rdData, 32'h0);
    check("R8 busAddr", 32'(busAddr), 32'h0);
    rst = 1'b0;

    // table walk: R1 R2 R4 R5 R6 R7 R3
    for (int v = 0; v < NV; v++) begin
      strobe(VECS[v].big, VECS[v].addr, VECS[v].size);
      check("R1 busAddr", 32'(busAddr), 32'(VECS[v].addr[31:2]));
      check(VECS[v].expMis ? "R7 byteEnN" : "R2 byteEnN", 32'(byteEnN), 32'(VECS[v].expEn));
      check(VECS[v].big ? "R5 busWrData" : "R4 busWrData", busWrData, VECS[v].expWr);
      check("R6 rdData", rdData, VECS[v].expRd);
      check("R7 misalign", 32'(misalign), 32'(VECS[v].expMis));
      check("R3 respValid", 32'(respValid), 32'h1);
    end

    // R3: outputs hold with no strobe while inputs change
    holdEn = byteEnN; holdWr = busWrData; holdRd = rdData; holdAddr = busAddr;
    bigEndian = 1'b0; addr = 32'h00000000; size = 2'd2;
    wrData = 32'hDEADBEEF; busRdData = 32'h01020304;
    @(negedge clk);
    check("R3 respValid low", 32'(respValid), 32'h0);
    @(negedge clk);
    check("R3 hold byteEnN", 32'(byteEnN), 32'(holdEn));
    check("R3 hold busWrData", busWrData, holdWr);
    check("R3 hold rdData", rdData, holdRd);
    check("R3 hold busAddr", 32'(busAddr), 32'(holdAddr));

    // R7 then aligned request clears error
    strobe(1'b1, 32'h00000003, 2'd1);
    check("R7 misalign set", 32'(misalign), 32'h1);
    strobe(1'b1, 32'h00000000, 2'd2);
    check("R7 misalign clear", 32'(misalign), 32'h0);

    // R8: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 byteEnN after reset", 32'(byteEnN), 32'hF);
    check("R8 busWrData after reset", busWrData, 32'h0);
    rst = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule